// File: doc/BRIEF.md
# Rate-1/3 Turbo Encoder with Table-Driven Permutation

This block turns a block of data bytes into a rate-1/3 turbo-coded byte stream. A start pulse gives the block length in bytes. The block then accepts exactly that many bytes over a valid/ready port and stores them in an on-chip byte buffer. Once the whole block is stored, a bit-serial core runs two identical recursive systematic convolutional encoders side by side.

The first encoder reads the data in natural order. The second reads the bit whose position comes back from an external permutation table. The block drives the table address and expects the table to answer in the same cycle. For each data bit the core emits three coded bits. After the last data bit it drives both encoders back to the all-zero state with three tail steps. Four zero bits then pad the stream to a byte boundary, and the result leaves as packed bytes with a one-cycle valid strobe.

Typical use is one encoder per transmit channel. A small ROM or RAM sits next to the block and holds the permutation for the block size in use.

Top module: `turbo_enc`

## Requirements
- R1: During and after reset, `inReady` and `outValid` are low until a start is accepted.
- R2: In the cycle after an accepted start, `inReady` goes high. It stays high until exactly `blockLen` bytes have been accepted (`inValid` and `inReady` both high at a clock edge), then drops. Bytes offered while `inReady` is low are ignored.
- R3: A block of L bytes produces exactly 3*L+2 output bytes, each flagged by a one-cycle `outValid`. No further bytes follow.
- R4: Data bit k is bit 7-(k mod 8) of input byte k/8, so the most significant bit comes first. For each k the stream carries, in order, the data bit, the parity bit of encoder 1 and the parity bit of encoder 2. Output bytes are filled from the most significant bit down.
- R5: Each encoder keeps three state bits s0 (newest), s1 and s2. With input u, feedback f = u^s1^s2 and parity = f^s0^s2. On each step the state becomes {s2,s1,s0} <= {s1,s0,f}.
- R6: While data bit k is encoded, `tblAddr` equals k. Encoder 2 takes as its input the stored data bit at position `tblData`, numbered as in R4.
- R7: Both encoder states are zero at the start of every block, so identical blocks give identical output.
- R8: After the last data bit come three tail steps. In each step the stream carries encoder 1's tail bit s1^s2, its parity s0^s2, encoder 2's tail bit and its parity, and then both states shift with zero feedback. Four zero bits follow.
- R9: A start pulse is ignored while a block is being loaded, encoded or terminated.
- R10: Block lengths from 1 byte up to MAX_BITS/8 bytes are handled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Start pulse, accepted only when idle |
| blockLen | input | LEN_W | Block length in bytes, 1..MAX_BITS/8 |
| inValid | input | 1 | Input byte valid |
| inReady | output | 1 | Block accepts input bytes |
| inData | input | 8 | Input data byte |
| tblAddr | output | IDX_W | Natural bit index sent to the permutation table |
| tblData | input | IDX_W | Permuted bit position returned by the table in the same cycle |
| outValid | output | 1 | Output byte strobe |
| outByte | output | 8 | Packed coded byte |

## Verification
The bench builds the encoder with MAX_BITS set to 512. A block of the largest size, 64 bytes, then fits into a few thousand cycles, and the buffer-index width, the bit-counter wrap and the final-bit detection are all exercised at their upper limit next to 1-byte blocks. The table seen by the bench is either a bit reversal of the block or an affine permutation with a multiplier coprime to the block length. Every table entry is therefore a legal position, and both far and near reads of the buffer occur.

// File: rtl/turbo_enc_pkg.sv
package turbo_enc_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LOAD,
    PH_ENC,
    PH_TAIL,
    PH_PAD
  } phase_t;

  // Strobes from control to datapath for one cycle
  typedef struct packed {
    logic       wrEn;      // store the accepted input byte
    logic       bitValid;  // one coded bit enters the packer
    logic       stepEn;    // advance both encoders
    logic       clrState;  // zero both encoders
    logic       tailMode;  // encoders run with zero feedback
    logic [1:0] sel;       // which coded bit is emitted
  } strobe_t;

endpackage

// File: rtl/turbo_enc_rsc.sv
module turbo_enc_rsc (
  input  logic clk,
  input  logic rstN,
  input  logic clr,
  input  logic step,
  input  logic tail,
  input  logic uBit,
  output logic parity,
  output logic tailBit
);
  logic [2:0] st;   // st[0] newest
  logic fb;

  always_comb begin
    fb      = tail ? 1'b0 : (uBit ^ st[1] ^ st[2]);
    parity  = fb ^ st[0] ^ st[2];
    tailBit = st[1] ^ st[2];
  end

  always_ff @(posedge clk) begin
    if (!rstN || clr) st <= '0;
    else if (step)    st <= {st[1:0], fb};
  end
endmodule

// File: rtl/turbo_enc_ctrl.sv
module turbo_enc_ctrl
  import turbo_enc_pkg::*;
#(
  parameter int MAX_BITS = 6144,
  parameter int LEN_W    = 10,
  parameter int IDX_W    = 13,
  parameter int BYTE_AW  = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startValid,
  input  logic [LEN_W-1:0]   blockLen,
  input  logic               inValid,
  output logic               inReady,
  output strobe_t            stb,
  output logic [BYTE_AW-1:0] wrAddr,
  output logic [IDX_W-1:0]   bitIdx
);
  phase_t             phase;
  logic [LEN_W-1:0]   lenReg;
  logic [BYTE_AW-1:0] byteCnt;
  logic [1:0]         sub;
  logic [1:0]         tailCnt;
  logic               lastByte, lastBit;

  assign lastByte = (32'(byteCnt) + 1) == 32'(lenReg);
  assign lastBit  = (32'(bitIdx) + 1) == (32'(lenReg) * 8);
  assign wrAddr   = byteCnt;
  assign inReady  = (phase == PH_LOAD);

  always_comb begin
    stb = '0;
    unique case (phase)
      PH_IDLE: stb.clrState = startValid;
      PH_LOAD: stb.wrEn = inValid;
      PH_ENC: begin
        stb.bitValid = 1'b1;
        stb.sel      = sub;
        stb.stepEn   = (sub == 2'd2);
      end
      PH_TAIL: begin
        stb.bitValid = 1'b1;
        stb.tailMode = 1'b1;
        stb.sel      = sub;
        stb.stepEn   = (sub == 2'd3);
      end
      PH_PAD: begin
        stb.bitValid = 1'b1;
        stb.sel      = 2'd3;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      lenReg  <= '0;
      byteCnt <= '0;
      bitIdx  <= '0;
      sub     <= '0;
      tailCnt <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (startValid) begin
          lenReg  <= blockLen;
          byteCnt <= '0;
          phase   <= PH_LOAD;
        end
        PH_LOAD: if (inValid) begin
          byteCnt <= byteCnt + 1'b1;
          if (lastByte) begin
            phase  <= PH_ENC;
            bitIdx <= '0;
            sub    <= '0;
          end
        end
        PH_ENC: begin
          if (sub == 2'd2) begin
            sub <= '0;
            if (lastBit) begin
              phase   <= PH_TAIL;
              tailCnt <= '0;
            end else begin
              bitIdx <= bitIdx + 1'b1;
            end
          end else begin
            sub <= sub + 1'b1;
          end
        end
        PH_TAIL: begin
          sub <= sub + 1'b1;
          if (sub == 2'd3) begin
            tailCnt <= tailCnt + 1'b1;
            if (tailCnt == 2'd2) phase <= PH_PAD;
          end
        end
        PH_PAD: begin
          sub <= sub + 1'b1;
          if (sub == 2'd3) phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/turbo_enc_dp.sv
module turbo_enc_dp
  import turbo_enc_pkg::*;
#(
  parameter int MAX_BITS = 6144,
  parameter int IDX_W    = 13,
  parameter int BYTE_AW  = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [BYTE_AW-1:0] wrAddr,
  input  logic [7:0]         inData,
  input  logic [IDX_W-1:0]   bitIdx,
  input  logic [IDX_W-1:0]   permIdx,
  output logic               outValid,
  output logic [7:0]         outByte
);
  localparam int BYTE_CNT = MAX_BITS / 8;

  logic [7:0] store [BYTE_CNT];
  logic [1:0] uBit, parity, tailBit;
  logic [IDX_W-1:0] rdIdx [2];
  logic       codeBit;
  logic [6:0] shReg;
  logic [2:0] fill;

  always_ff @(posedge clk) begin
    if (stb.wrEn) store[wrAddr] <= inData;
  end

  assign rdIdx[0] = bitIdx;
  assign rdIdx[1] = permIdx;

  for (genvar gi = 0; gi < 2; gi++) begin : g_enc
    logic [7:0] rdByte;
    assign rdByte   = store[rdIdx[gi][IDX_W-1:3]];
    assign uBit[gi] = rdByte[~rdIdx[gi][2:0]];

    turbo_enc_rsc u_rsc (
      .clk     (clk),
      .rstN    (rstN),
      .clr     (stb.clrState),
      .step    (stb.stepEn),
      .tail    (stb.tailMode),
      .uBit    (uBit[gi]),
      .parity  (parity[gi]),
      .tailBit (tailBit[gi])
    );
  end

  always_comb begin
    if (stb.tailMode) begin
      unique case (stb.sel)
        2'd0:    codeBit = tailBit[0];
        2'd1:    codeBit = parity[0];
        2'd2:    codeBit = tailBit[1];
        default: codeBit = parity[1];
      endcase
    end else begin
      unique case (stb.sel)
        2'd0:    codeBit = uBit[0];
        2'd1:    codeBit = parity[0];
        2'd2:    codeBit = parity[1];
        default: codeBit = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fill     <= '0;
      shReg    <= '0;
      outValid <= 1'b0;
      outByte  <= '0;
    end else begin
      outValid <= 1'b0;
      if (stb.bitValid) begin
        fill  <= fill + 1'b1;
        shReg <= {shReg[5:0], codeBit};
        if (fill == 3'd7) begin
          outValid <= 1'b1;
          outByte  <= {shReg, codeBit};
        end
      end
    end
  end
endmodule

// File: rtl/turbo_enc.sv
module turbo_enc
  import turbo_enc_pkg::*;
#(
  parameter int MAX_BITS = 6144,
  localparam int BYTE_CNT = MAX_BITS / 8,
  localparam int LEN_W    = $clog2(BYTE_CNT + 1),
  localparam int IDX_W    = $clog2(MAX_BITS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startValid,
  input  logic [LEN_W-1:0] blockLen,
  input  logic             inValid,
  output logic             inReady,
  input  logic [7:0]       inData,
  output logic [IDX_W-1:0] tblAddr,
  input  logic [IDX_W-1:0] tblData,
  output logic             outValid,
  output logic [7:0]       outByte
);
  localparam int BYTE_AW = IDX_W - 3;

  strobe_t            stb;
  logic [BYTE_AW-1:0] wrAddr;
  logic [IDX_W-1:0]   bitIdx;

  assign tblAddr = bitIdx;

  turbo_enc_ctrl #(
    .MAX_BITS(MAX_BITS), .LEN_W(LEN_W), .IDX_W(IDX_W), .BYTE_AW(BYTE_AW)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .startValid(startValid), .blockLen(blockLen),
    .inValid(inValid), .inReady(inReady), .stb(stb), .wrAddr(wrAddr),
    .bitIdx(bitIdx)
  );

  turbo_enc_dp #(
    .MAX_BITS(MAX_BITS), .IDX_W(IDX_W), .BYTE_AW(BYTE_AW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrAddr(wrAddr), .inData(inData),
    .bitIdx(bitIdx), .permIdx(tblData), .outValid(outValid), .outByte(outByte)
  );
endmodule

// File: rtl/turbo_enc_chk.sv
module turbo_enc_chk #(
  parameter int LEN_W = 10,
  parameter int IDX_W = 13
) (
  input logic             clk,
  input logic             rstN,
  input logic             startValid,
  input logic [LEN_W-1:0] blockLen,
  input logic             inValid,
  input logic             inReady,
  input logic [IDX_W-1:0] tblAddr,
  input logic             outValid
);
  logic [LEN_W-1:0] lenPrev;
  logic             readyPrev;
  int               outCnt, outLimit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenPrev   <= '0;
      readyPrev <= 1'b0;
      outCnt    <= 0;
      outLimit  <= 0;
    end else begin
      lenPrev   <= blockLen;
      readyPrev <= inReady;
      if (inReady && !readyPrev) begin
        outLimit <= 3 * int'(lenPrev) + 2;
        outCnt   <= 0;
      end else if (outValid) begin
        outCnt <= outCnt + 1;
      end
    end
  end

  AST_NO_OUT_WHILE_LOADING: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> !outValid); // R2

  AST_OUT_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !(inReady && !readyPrev)) |-> outCnt < outLimit); // R3

  AST_OUT_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid); // R4

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (inReady && startValid && !inValid) |=> inReady); // R9

  AST_TBL_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(tblAddr) |-> (tblAddr == $past(tblAddr) + 1'b1 || tblAddr == '0)); // R6
endmodule

bind turbo_enc turbo_enc_chk #(.LEN_W(LEN_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .startValid(startValid), .blockLen(blockLen),
  .inValid(inValid), .inReady(inReady), .tblAddr(tblAddr), .outValid(outValid)
);

// File: tb/turbo_enc_bench.sv
`timescale 1ns/1ps
module turbo_enc_bench;
  localparam int MAX_BITS  = 512;
  localparam int MAX_BYTES = MAX_BITS / 8;
  localparam int LEN_W     = $clog2(MAX_BYTES + 1);
  localparam int IDX_W     = $clog2(MAX_BITS);
  localparam int OUT_MAX   = 3 * MAX_BYTES + 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rstN, startValid, inValid, inReady, outValid;
  logic [LEN_W-1:0] blockLen;
  logic [7:0]       inData, outByte;
  logic [IDX_W-1:0] tblAddr, tblData;

  turbo_enc #(.MAX_BITS(MAX_BITS)) u_turbo_enc (
    .clk(clk), .rstN(rstN), .startValid(startValid), .blockLen(blockLen),
    .inValid(inValid), .inReady(inReady), .inData(inData),
    .tblAddr(tblAddr), .tblData(tblData), .outValid(outValid), .outByte(outByte)
  );

  int nRun = 0, nFail = 0, cyc = 0;
  logic [7:0] dat  [MAX_BYTES];
  logic [7:0] expB [OUT_MAX];
  logic [7:0] got  [OUT_MAX + 8];
  logic [7:0] prevGot [OUT_MAX];
  int gotCnt = 0, expN = 0, accN = 0;
  logic [7:0] accB;
  int curBits = 8, permA = 1;
  bit permRev = 1'b0;

  function automatic int perm(int k);
    if (k >= curBits) return 0;
    if (permRev) return curBits - 1 - k;
    return (permA * k + 5) % curBits;
  endfunction

  assign tblData = IDX_W'(perm(int'(tblAddr)));

  function automatic int gcd(int a, int b);
    while (b != 0) begin
      int t = a % b;
      a = b;
      b = t;
    end
    return a;
  endfunction

  function automatic logic dbit(int k);
    return dat[k / 8][7 - (k % 8)];
  endfunction

  always @(negedge clk) begin
    if (outValid && gotCnt < OUT_MAX + 8) begin
      got[gotCnt] = outByte;
      gotCnt++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic pushBit(input logic b);
    accB = {accB[6:0], b};
    accN++;
    if (accN == 8) begin
      expB[expN] = accB;
      expN++;
      accN = 0;
    end
  endtask

  // Reference: R4 R5 R6 R7 R8
  task automatic buildExp(input int nBytes);
    logic [2:0] s1, s2;
    logic u1, u2, f1, f2;
    expN = 0; accN = 0; s1 = '0; s2 = '0;
    for (int k = 0; k < nBytes * 8; k++) begin
      u1 = dbit(k);
      u2 = dbit(perm(k));
      f1 = u1 ^ s1[1] ^ s1[2];
      f2 = u2 ^ s2[1] ^ s2[2];
      pushBit(u1);
      pushBit(f1 ^ s1[0] ^ s1[2]);
      pushBit(f2 ^ s2[0] ^ s2[2]);
      s1 = {s1[1:0], f1};
      s2 = {s2[1:0], f2};
    end
    for (int t = 0; t < 3; t++) begin
      pushBit(s1[1] ^ s1[2]);
      pushBit(s1[0] ^ s1[2]);
      pushBit(s2[1] ^ s2[2]);
      pushBit(s2[0] ^ s2[2]);
      s1 = {s1[1:0], 1'b0};
      s2 = {s2[1:0], 1'b0};
    end
    for (int p = 0; p < 4; p++) pushBit(1'b0);
  endtask

  task automatic runBlock(input int nBytes, input bit rev, input int pressure,
                          input bit midStart, input string tag);
    int idx = 0, guard = 0;
    bit rdy;
    permRev = rev;
    curBits = nBytes * 8;
    permA = 3 + 2 * int'($urandom % 20);
    while (gcd(permA, curBits) != 1) permA += 2;
    buildExp(nBytes);
    gotCnt = 0;
    @(negedge clk);
    startValid = 1'b1;
    blockLen   = LEN_W'(nBytes);
    @(negedge clk);
    startValid = 1'b0;
    while (idx < nBytes && guard < 20000) begin
      inValid = (int'($urandom % 100) < pressure);
      inData  = dat[idx];
      if (midStart && idx == 1) begin   // R9: start during load
        startValid = 1'b1;
        blockLen   = LEN_W'((nBytes % MAX_BYTES) + 1);
      end
      rdy = inReady;
      @(negedge clk);
      startValid = 1'b0;
      if (inValid && rdy) idx++;
      guard++;
    end
    // R2: ready drops after the last byte, extra bytes are offered and ignored
    chk(inReady == 1'b0, {"R2 ready low after load ", tag}, int'(inReady), 0);
    inValid = 1'b1;
    inData  = 8'hA5;
    guard = 0;
    while (gotCnt < expN && guard < 4 * curBits + 200) begin
      if (midStart && guard == 7) startValid = 1'b1;   // R9: start during encode
      @(negedge clk);
      startValid = 1'b0;
      guard++;
    end
    inValid = 1'b0;
    repeat (30) @(negedge clk);
    chk(gotCnt == 3 * nBytes + 2, {"R3 byte count ", tag}, gotCnt, 3 * nBytes + 2);
    for (int i = 0; i < expN; i++) begin
      if (i < 3 * nBytes)
        chk(got[i] === expB[i], {"R4 R5 R6 coded byte ", tag}, int'(got[i]), int'(expB[i]));
      else
        chk(got[i] === expB[i], {"R8 tail byte ", tag}, int'(got[i]), int'(expB[i]));
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    rstN = 1'b0; startValid = 1'b0; inValid = 1'b0; inData = '0; blockLen = '0;
    repeat (3) @(negedge clk);
    chk(inReady == 1'b0 && outValid == 1'b0, "R1 in reset", int'({inReady, outValid}), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(inReady == 1'b0 && outValid == 1'b0, "R1 after reset", int'({inReady, outValid}), 0);

    // R10 shortest block, all zeros then all ones
    dat[0] = 8'h00;
    runBlock(1, 1'b0, 100, 1'b0, "R10 min zeros");
    dat[0] = 8'hFF;
    runBlock(1, 1'b1, 100, 1'b0, "R10 min ones");

    // R10 longest block
    for (int i = 0; i < MAX_BYTES; i++) dat[i] = 8'($urandom);
    runBlock(MAX_BYTES, 1'b0, 70, 1'b0, "R10 max");

    // R7: identical block twice, outputs must match
    for (int i = 0; i < 5; i++) dat[i] = 8'($urandom);
    runBlock(5, 1'b1, 100, 1'b0, "R7 first");
    for (int i = 0; i < 3 * 5 + 2; i++) prevGot[i] = got[i];
    runBlock(5, 1'b1, 50, 1'b0, "R7 second");
    for (int i = 0; i < 3 * 5 + 2; i++)
      chk(got[i] === prevGot[i], "R7 repeat matches", int'(got[i]), int'(prevGot[i]));

    // R9: start pulses while busy
    for (int i = 0; i < 9; i++) dat[i] = 8'($urandom);
    runBlock(9, 1'b0, 60, 1'b1, "R9 busy start");

    // Random blocks
    for (int b = 0; b < 10; b++) begin
      int n = 1 + int'($urandom % MAX_BYTES);
      for (int i = 0; i < n; i++) dat[i] = 8'($urandom);
      runBlock(n, 1'($urandom), 30 + int'($urandom % 70), 1'($urandom), "random");
    end

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule